// File: doc/BRIEF.md
# Run-Aware Timing Source Selector

This block chooses, for each of four timing outputs, which source drives it: the main bunch clock, orbit 1, orbit 2 and the main orbit. Each choice is a 2-bit select code. A downstream multiplexer uses these codes to switch the real clock and orbit signals, and that multiplexer is not part of this block. Software writes the configuration through a simple write port. Eight-bit source sets pack the four select codes.

In manual mode the outputs follow one software-written set directly. In each of the three automatic modes, a 16-entry run map classifies the incoming 4-bit machine-state code as run or no-run. A no-run state selects the shared no-run set. A run state selects the run set that belongs to the active automatic mode. A typical setup keeps the main bunch clock on the internal oscillator outside physics and moves it to the reference bunch clock once the machine state is marked as run.

Top module: `timing_src_sel`

## Requirements
- R1: While `rst_n` is low, all select outputs and `run_active` are 0. Reset returns the configuration to manual mode and sets the run map and every source set to zero.
- R2: The write port decodes these addresses: 0 mode, 1 run map, 2 manual set, 3 no-run set, 4/5/6 run sets for auto1/auto2/auto3. In manual mode (mode code 0) the outputs equal the manual set, whatever the machine-state code is.
- R3: `run_active` is bit `mach_code` of the 16-bit run map (1 means run). It is reported in every mode, including manual.
- R4: In an automatic mode (mode code 1, 2 or 3), when the current machine-state code maps to no-run, the outputs equal the no-run set (address 3).
- R5: In automatic mode k (k = 1..3), when the current machine-state code maps to run, the outputs equal run set k (address 3+k).
- R6: The outputs and `run_active` are registered. They use the `mach_code` sampled at a clock edge and the configuration as it stood before that edge. A write accepted at edge n therefore shows at the outputs from edge n+1 onward.
- R7: A write to address 7 changes nothing. A mode write uses only `cfg_wdata[1:0]`. A set write uses only `cfg_wdata[7:0]`.
- R8: Each set packs its fields as follows: [1:0] main bunch clock (0 BC1, 1 BC2, 2 BCref, 3 internal clock), [3:2] orbit 1, [5:4] orbit 2, [7:6] main orbit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| mach_code | input | 4 | Machine-state code |
| sel_bc_main | output | 2 | Main bunch-clock source select |
| sel_orb1 | output | 2 | Orbit 1 source select |
| sel_orb2 | output | 2 | Orbit 2 source select |
| sel_orb_main | output | 2 | Main orbit source select |
| run_active | output | 1 | Current machine state classified as run |

## Verification
A configuration write and a change of the machine-state code can land on the same clock edge. At that edge the outputs must take the new code against the old configuration, and at the following edge both changes must be in effect. The bench drives both in one cycle, including writes to the run map and the mode. A behavioural model updates its registers after it forms each cycle's prediction, and every cycle's outputs are compared against that prediction.

// File: rtl/tss_pkg.sv
package tss_pkg;
    localparam int CODE_W   = 4;
    localparam int SEL_W    = 2;
    localparam int N_OUT    = 4;
    localparam int N_AUTO   = 3;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 16;

    localparam int ADDR_MODE   = 0;
    localparam int ADDR_MAP    = 1;
    localparam int ADDR_MANUAL = 2;
    localparam int ADDR_NORUN  = 3;
    localparam int ADDR_RUN0   = 4;

    typedef enum logic [1:0] {
        MODE_MANUAL = 2'd0,
        MODE_AUTO1  = 2'd1,
        MODE_AUTO2  = 2'd2,
        MODE_AUTO3  = 2'd3
    } mode_e;
endpackage

// File: rtl/tss_cfg_regs.sv
module tss_cfg_regs
    import tss_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int SET_W  = 8,
    parameter int N_AUTO = 3,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output mode_e                         mode_q,
    output logic [(1<<CODE_W)-1:0]        map_q,
    output logic [SET_W-1:0]              manual_q,
    output logic [SET_W-1:0]              norun_q,
    output logic [N_AUTO-1:0][SET_W-1:0]  run_q
);
    localparam int MAP_W = 1 << CODE_W;

    typedef struct packed {
        mode_e                         mode;
        logic [MAP_W-1:0]              map;
        logic [SET_W-1:0]              manual;
        logic [SET_W-1:0]              norun;
        logic [N_AUTO-1:0][SET_W-1:0]  run;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == ADDR_W'(ADDR_MODE))   cfg_d.mode   = mode_e'(wdata[1:0]);
            if (addr == ADDR_W'(ADDR_MAP))    cfg_d.map    = wdata[MAP_W-1:0];
            if (addr == ADDR_W'(ADDR_MANUAL)) cfg_d.manual = wdata[SET_W-1:0];
            if (addr == ADDR_W'(ADDR_NORUN))  cfg_d.norun  = wdata[SET_W-1:0];
            for (int i = 0; i < N_AUTO; i++) begin
                if (addr == ADDR_W'(ADDR_RUN0 + i)) cfg_d.run[i] = wdata[SET_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode_q   = cfg_q.mode;
    assign map_q    = cfg_q.map;
    assign manual_q = cfg_q.manual;
    assign norun_q  = cfg_q.norun;
    assign run_q    = cfg_q.run;
endmodule

// File: rtl/tss_classify.sv
module tss_classify #(
    parameter int CODE_W = 4
) (
    input  logic [(1<<CODE_W)-1:0] map,
    input  logic [CODE_W-1:0]      code,
    output logic                   is_run
);
    always_comb begin
        is_run = map[code];
    end
endmodule

// File: rtl/tss_route.sv
module tss_route
    import tss_pkg::*;
#(
    parameter int SET_W  = 8,
    parameter int N_AUTO = 3
) (
    input  mode_e                         mode,
    input  logic                          is_run,
    input  logic [SET_W-1:0]              manual,
    input  logic [SET_W-1:0]              norun,
    input  logic [N_AUTO-1:0][SET_W-1:0]  run,
    output logic [SET_W-1:0]              chosen
);
    logic [1:0] mode_bits;
    assign mode_bits = mode;

    always_comb begin
        if (mode == MODE_MANUAL) begin
            chosen = manual;
        end else if (!is_run) begin
            chosen = norun;
        end else begin
            chosen = norun;
            for (int i = 0; i < N_AUTO; i++) begin
                if (mode_bits == 2'(i + 1)) chosen = run[i];
            end
        end
    end
endmodule

// File: rtl/timing_src_sel.sv
module timing_src_sel
    import tss_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int SEL_W  = 2,
    parameter int N_AUTO = 3,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [CODE_W-1:0] mach_code,
    output logic [SEL_W-1:0]  sel_bc_main,
    output logic [SEL_W-1:0]  sel_orb1,
    output logic [SEL_W-1:0]  sel_orb2,
    output logic [SEL_W-1:0]  sel_orb_main,
    output logic              run_active
);
    localparam int N_OUT = 4;
    localparam int SET_W = SEL_W * N_OUT;
    localparam int MAP_W = 1 << CODE_W;

    mode_e                         cfg_mode;
    logic [MAP_W-1:0]              cfg_map;
    logic [SET_W-1:0]              cfg_manual;
    logic [SET_W-1:0]              cfg_norun;
    logic [N_AUTO-1:0][SET_W-1:0]  cfg_run;
    logic                          is_run;
    logic [SET_W-1:0]              chosen;

    tss_cfg_regs #(
        .CODE_W(CODE_W), .SET_W(SET_W), .N_AUTO(N_AUTO),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .mode_q(cfg_mode), .map_q(cfg_map), .manual_q(cfg_manual),
        .norun_q(cfg_norun), .run_q(cfg_run)
    );

    tss_classify #(.CODE_W(CODE_W)) u_cls (
        .map(cfg_map), .code(mach_code), .is_run(is_run)
    );

    tss_route #(.SET_W(SET_W), .N_AUTO(N_AUTO)) u_route (
        .mode(cfg_mode), .is_run(is_run), .manual(cfg_manual),
        .norun(cfg_norun), .run(cfg_run), .chosen(chosen)
    );

    typedef struct packed {
        logic [SET_W-1:0] sel;
        logic             run;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.sel = chosen;
        out_d.run = is_run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sel_bc_main  = out_q.sel[0*SEL_W +: SEL_W];
    assign sel_orb1     = out_q.sel[1*SEL_W +: SEL_W];
    assign sel_orb2     = out_q.sel[2*SEL_W +: SEL_W];
    assign sel_orb_main = out_q.sel[3*SEL_W +: SEL_W];
    assign run_active   = out_q.run;
endmodule

// File: rtl/tss_checker.sv
module tss_checker
    import tss_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int SEL_W  = 2,
    parameter int N_AUTO = 3,
    parameter int ADDR_W = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [CODE_W-1:0]                      code,
    input  mode_e                                  mode,
    input  logic [(1<<CODE_W)-1:0]                 map,
    input  logic [SEL_W*4-1:0]                     manual,
    input  logic [SEL_W*4-1:0]                     norun,
    input  logic [N_AUTO-1:0][SEL_W*4-1:0]         run,
    input  logic [SEL_W-1:0]                       o_bc,
    input  logic [SEL_W-1:0]                       o_orb1,
    input  logic [SEL_W-1:0]                       o_orb2,
    input  logic [SEL_W-1:0]                       o_orbm,
    input  logic                                   o_run
);
    localparam int SET_W = SEL_W * 4;
    logic [SET_W-1:0] out_set;
    logic             past_ok;
    logic             cls_run;
    logic             dead_wr;

    assign out_set = {o_orbm, o_orb2, o_orb1, o_bc};
    assign cls_run = map[code];
    assign dead_wr = we && (addr >= ADDR_W'(ADDR_RUN0 + N_AUTO));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (out_set == '0 && !o_run));

    assert_manual_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode) == MODE_MANUAL |-> out_set == $past(manual));

    assert_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> o_run == $past(cls_run));

    assert_norun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode) != MODE_MANUAL && !$past(cls_run) |-> out_set == $past(norun));

    for (genvar k = 0; k < N_AUTO; k++) begin : g_run
        assert_runset_R5: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(mode) == mode_e'(k + 1) && $past(cls_run) |-> out_set == $past(run[k]));
    end

    assert_dead_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(dead_wr) |->
            (mode == $past(mode) && map == $past(map) && manual == $past(manual) &&
             norun == $past(norun) && run == $past(run)));
endmodule

bind timing_src_sel tss_checker #(
    .CODE_W(CODE_W), .SEL_W(SEL_W), .N_AUTO(N_AUTO), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .code(mach_code),
    .mode(cfg_mode), .map(cfg_map), .manual(cfg_manual), .norun(cfg_norun), .run(cfg_run),
    .o_bc(sel_bc_main), .o_orb1(sel_orb1), .o_orb2(sel_orb2), .o_orbm(sel_orb_main),
    .o_run(run_active)
);

// File: tb/timing_src_sel_bench.sv
module timing_src_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  mach_code = '0;
    logic [1:0]  sel_bc_main, sel_orb1, sel_orb2, sel_orb_main;
    logic        run_active;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string tag_override = "";

    always #10 clk = ~clk;

    timing_src_sel u_timing_src_sel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mach_code(mach_code),
        .sel_bc_main(sel_bc_main), .sel_orb1(sel_orb1), .sel_orb2(sel_orb2),
        .sel_orb_main(sel_orb_main), .run_active(run_active)
    );

    // behavioural reference model
    logic [1:0]  m_mode;
    logic [15:0] m_map;
    logic [7:0]  m_manual, m_norun;
    logic [7:0]  m_run [3];
    logic [7:0]  exp_sel;
    logic        exp_run;
    string       exp_tag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_map = 0; m_manual = 0; m_norun = 0;
            for (int i = 0; i < 3; i++) m_run[i] = 0;
            exp_sel = 0; exp_run = 0; exp_tag = "R1";
        end else begin
            exp_run = m_map[mach_code];
            if (m_mode == 0) begin
                exp_sel = m_manual; exp_tag = "R2";
            end else if (!exp_run) begin
                exp_sel = m_norun; exp_tag = "R4";
            end else begin
                exp_sel = m_run[m_mode - 1]; exp_tag = "R5";
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_mode = cfg_wdata[1:0];
                    3'd1: m_map = cfg_wdata;
                    3'd2: m_manual = cfg_wdata[7:0];
                    3'd3: m_norun = cfg_wdata[7:0];
                    3'd4: m_run[0] = cfg_wdata[7:0];
                    3'd5: m_run[1] = cfg_wdata[7:0];
                    3'd6: m_run[2] = cfg_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] got;
            string t;
            got = {sel_orb_main, sel_orb2, sel_orb1, sel_bc_main};
            t = (tag_override != "") ? tag_override : exp_tag;
            vectors++;
            if (got !== exp_sel) begin
                miscompares++;
                $display("FAIL %s R8 selects: got %02h expected %02h at %0t", t, got, exp_sel, $time);
            end
            vectors++;
            if (run_active !== exp_run) begin
                miscompares++;
                $display("FAIL R3 run_active: got %0b expected %0b at %0t", run_active, exp_run, $time);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_code(input logic [2:0] a, input logic [15:0] d, input logic [3:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; mach_code = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sweep_codes();
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            mach_code = 4'(c);
        end
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        tag_override = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag_override = "";
        repeat (2) @(negedge clk);

        // R8 / R2: manual set fields, code changes have no effect
        wr(3'd2, 16'h00E4);
        repeat (2) @(negedge clk);
        sweep_codes();

        // R3: run map classification in manual mode
        wr(3'd1, 16'hA5C3);
        sweep_codes();

        // load no-run and three run sets
        wr(3'd3, 16'h001B);
        wr(3'd4, 16'h006C);
        wr(3'd5, 16'h00B1);
        wr(3'd6, 16'h00D2);

        // R4 / R5: each automatic mode across all codes
        for (int m = 1; m <= 3; m++) begin
            wr(3'd0, 16'(m));
            sweep_codes();
        end

        // R6: write and code change on the same edge
        tag_override = "R6";
        wr_code(3'd1, 16'h5A3C, 4'd2);
        wr_code(3'd0, 16'h0001, 4'd3);
        wr_code(3'd4, 16'h0039, 4'd5);
        wr_code(3'd3, 16'h00C6, 4'd0);
        wr_code(3'd0, 16'h0000, 4'd9);
        repeat (2) @(negedge clk);

        // R7: dead address and upper data bits ignored
        tag_override = "R7";
        wr(3'd7, 16'hFFFF);
        repeat (2) @(negedge clk);
        wr(3'd2, 16'hFF27);
        repeat (2) @(negedge clk);
        wr(3'd0, 16'hFFFE);
        sweep_codes();
        wr(3'd7, 16'h0000);
        sweep_codes();
        tag_override = "";

        // back to manual
        wr(3'd0, 16'h0000);
        repeat (3) @(negedge clk);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule